// File: doc/BRIEF.md
# Successive Approximation Control Register

This block steps a binary-search analog-to-digital conversion, deciding one bit per clock. An external comparator looks at the register's parallel outputs through a ladder network and returns one bit. The block keeps that bit in the position under trial and moves the trial on to the next lower position. The converted code is the bitwise complement of `code_q`. The trial bit is driven low, and bits not yet tried sit high. For a comparator this means: `cmp_bit` is 0 when the analog input is at or above the trial code `~code_q`, and 1 when it is below.

A `busy` flag stays high for the whole conversion. Feeding `busy` straight back into `start_n` makes the register convert continuously. `trunc8` shortens each conversion to the top eight bits. `chain_en` freezes the register and forces the MSB output high, so that several registers can be chained into a longer word. `cmp_dly` carries the comparator bit, delayed by one clock, to the next stage of a chain.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, `code_q` is all ones, `busy` is 0 and `cmp_dly` is 0, until the first start.
- R2: A rising edge of `clk` with `start_n` = 0 and `chain_en` = 0 loads `code_q` = 12'h7FF (bit 11 = 0, all others 1) and sets `busy` to 1. This holds even when a conversion is already in progress, so the conversion restarts.
- R3: On each later edge of a conversion, the bit under trial takes the value of `cmp_bit`, and the next lower bit becomes 0 as the new trial bit. Bits already resolved keep their values.
- R4: In 12-bit mode, `busy` stays 1 through the edge that resolves bit 11 down to the edge that resolves bit 0, which is the 12th edge after the load. It falls on that edge. `code_q` then holds its value until the next start.
- R5: If a comparator returns 0 exactly when the target code is at or above `~code_q`, then `~code_q` equals the target 12 edges after the load, for every 12-bit target.
- R6: `cmp_dly` equals `cmp_bit` as it was at the previous rising edge of `clk`.
- R7: While `chain_en` = 1, `code_q[11]` and `msb` read 1. The stored register and the conversion progress are frozen, and `start_n` is ignored. When `chain_en` falls, the conversion resumes where it stopped.
- R8: `msb_n` is always the complement of `msb`, and `msb` equals `code_q[11]`.
- R9: With `trunc8` = 1, `busy` falls on the edge that resolves bit 4, which is the 8th edge after the load. Bits 3..0 stay 1, so `~code_q` equals the target with its low four bits cleared.
- R10: With `start_n` driven directly from `busy`, the edge right after the edge on which `busy` fell loads a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Start request, active low, sampled on the edge |
| cmp_bit | input | 1 | Comparator result for the current trial bit |
| chain_en | input | 1 | Chaining hold: freezes the register and forces the MSB high |
| trunc8 | input | 1 | Selects 8-bit conversions |
| code_q | output | 12 | Parallel register bits; the converted code is their complement |
| msb | output | 1 | True MSB output |
| msb_n | output | 1 | Complemented MSB output |
| busy | output | 1 | High while a conversion runs |
| cmp_dly | output | 1 | `cmp_bit` delayed by one clock |

## Verification
The bench sweeps every 12-bit target and targets at the code boundaries (0, 4095, single-bit codes). An off-by-one in the trial pointer or an inverted comparator sense shows up there as a wrong LSB or a stuck MSB. It also checks that completion falls on exactly the 12th edge, or the 8th in truncated mode. An early flag would leave bit 0 unresolved, and a late flag would break continuous mode, which a feedback test confirms by expecting a reload on the very next edge. A hold through `chain_en` in mid-conversion catches a design that only masks the output and lets the trial advance. A restart in mid-conversion catches a start that is ignored while busy.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // One-hot mask of the last bit resolved for a given mode
    function automatic logic [31:0] stop_mask(input int unsigned width,
                                              input int unsigned short_w,
                                              input logic        short_mode);
        logic [31:0] m;
        m = 32'd1;
        if (short_mode)
            m = 32'd1 << (width - short_w);
        return m;
    endfunction

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH   = 12,
    parameter int unsigned SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic             hold,
    input  logic             short_mode,
    output logic [WIDTH-1:0] trial,
    output logic             busy,
    output logic             load,
    output logic             advance
);

    localparam logic [WIDTH-1:0] TOP_HOT = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] ptr;
        logic             busy;
    } seq_t;

    seq_t             st_q, st_d;
    logic [WIDTH-1:0] stop_oh;
    logic             at_stop;

    always_comb begin
        stop_oh = WIDTH'(stop_mask(WIDTH, SHORT_W, short_mode));
        at_stop = |(st_q.ptr & stop_oh);
        load    = !hold && !start_n;
        advance = !hold && start_n && st_q.busy && !at_stop;
        st_d    = st_q;
        if (load) begin
            st_d.ptr  = TOP_HOT;
            st_d.busy = 1'b1;
        end else if (!hold && st_q.busy) begin
            if (at_stop) begin
                st_d.ptr  = '0;
                st_d.busy = 1'b0;
            end else begin
                st_d.ptr = st_q.ptr >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trial = st_q.ptr;
    assign busy  = st_q.busy;

    // R3: at most one bit under trial
    a_r3_single_trial: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.ptr));
    // R4: completion only after the stop bit was under trial
    a_r4_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(at_stop));
    // R7: chaining hold freezes the sequence
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.ptr) && $stable(st_q.busy));

endmodule

// File: rtl/sar_bitreg.sv
module sar_bitreg #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             busy,
    input  logic             hold,
    input  logic [WIDTH-1:0] trial,
    input  logic             cmp_bit,
    output logic [WIDTH-1:0] bits
);

    localparam logic [WIDTH-1:0] LOAD_VAL = {1'b0, {(WIDTH-1){1'b1}}};

    logic [WIDTH-1:0] bits_q, bits_d;

    always_comb begin
        bits_d = bits_q;
        if (load) begin
            bits_d = LOAD_VAL;
        end else if (!hold && busy) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (trial[i])
                    bits_d[i] = cmp_bit;
                else if (i < WIDTH - 1 && trial[i+1] && advance)
                    bits_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '1;
        else        bits_q <= bits_d;
    end

    assign bits = bits_q;

    // R2: a start loads the trial pattern
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bits_q == LOAD_VAL);
    // R3: only the trial bit and its lower neighbour may change
    a_r3_resolved_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((bits_q ^ $past(bits_q)) & ~($past(trial) | ($past(trial) >> 1))) == '0);

endmodule

// File: rtl/sar_serial_dly.sv
module sar_serial_dly (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic dly_q, dly_d;

    always_comb dly_d = din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= 1'b0;
        else        dly_q <= dly_d;
    end

    assign dout = dly_q;

    // R6: one-clock delay
    a_r6_serial_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dly_q == $past(din));

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int unsigned WIDTH   = 12,
    parameter int unsigned SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic             cmp_bit,
    input  logic             chain_en,
    input  logic             trunc8,
    output logic [WIDTH-1:0] code_q,
    output logic             msb,
    output logic             msb_n,
    output logic             busy,
    output logic             cmp_dly
);

    logic [WIDTH-1:0] trial;
    logic [WIDTH-1:0] bits;
    logic             load;
    logic             advance;
    logic             busy_w;

    sar_sequencer #(.WIDTH(WIDTH), .SHORT_W(SHORT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_n    (start_n),
        .hold       (chain_en),
        .short_mode (trunc8),
        .trial      (trial),
        .busy       (busy_w),
        .load       (load),
        .advance    (advance)
    );

    sar_bitreg #(.WIDTH(WIDTH)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .busy    (busy_w),
        .hold    (chain_en),
        .trial   (trial),
        .cmp_bit (cmp_bit),
        .bits    (bits)
    );

    sar_serial_dly u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_bit),
        .dout  (cmp_dly)
    );

    always_comb begin
        code_q          = bits;
        code_q[WIDTH-1] = bits[WIDTH-1] | chain_en;
        msb             = code_q[WIDTH-1];
        msb_n           = ~code_q[WIDTH-1];
        busy            = busy_w;
    end

    // R7: chaining forces the MSB output high
    a_r7_msb_forced: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en |-> msb && !msb_n);
    // R8: complementary MSB pair
    a_r8_msb_pair: assert property (@(posedge clk) disable iff (!rst_n)
        msb_n == ~msb);

endmodule

// File: tb/sar_ctrl_tb_top.sv
module sar_ctrl_tb_top;

    localparam int unsigned W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_n = 1'b1;
    logic         chain_en = 1'b0;
    logic         trunc8 = 1'b0;
    logic         use_model = 1'b1;
    logic         cmp_force = 1'b0;
    logic         feedback = 1'b0;
    logic [W-1:0] target = '0;
    logic         cmp_bit;
    logic         start_drv;
    logic [W-1:0] code_q;
    logic         msb, msb_n, busy, cmp_dly;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    // Comparator model: 0 when target is at or above the trial code (~code_q)
    assign cmp_bit   = use_model ? ((target >= ~code_q) ? 1'b0 : 1'b1) : cmp_force;
    assign start_drv = feedback ? busy : start_n;

    sar_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_n  (start_drv),
        .cmp_bit  (cmp_bit),
        .chain_en (chain_en),
        .trunc8   (trunc8),
        .code_q   (code_q),
        .msb      (msb),
        .msb_n    (msb_n),
        .busy     (busy),
        .cmp_dly  (cmp_dly)
    );

    localparam int NV = 8;
    localparam logic [W-1:0] VEC_TGT [NV] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                              12'h001, 12'hA5A, 12'h5A5, 12'h3C7};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Load on one edge, then n resolving edges; ends just after a negedge
    task automatic convert(input logic [W-1:0] tgt, input int n);
        target = tgt;
        @(negedge clk); start_n = 1'b0;
        @(posedge clk);
        @(negedge clk); start_n = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(code_q == '1 && !busy && !cmp_dly, "R1", code_q, 12'hFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(code_q == '1 && !busy, "R1", {busy, code_q}, 12'hFFF);

        // R2 load pattern and busy
        target = 12'h123;
        start_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(code_q == 12'h7FF && busy, "R2", code_q, 12'h7FF);
        start_n = 1'b1;
        // R3 first resolution: bit 11 kept, bit 10 becomes trial 0
        @(posedge clk); @(negedge clk);
        check(code_q == 12'hBFF, "R3", code_q, 12'hBFF);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(busy, "R4 busy before last", busy, 1);
        @(posedge clk); @(negedge clk);
        check(!busy && code_q == ~12'h123, "R4 done", code_q, ~12'h123);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(code_q == ~12'h123 && !busy, "R4 hold", code_q, ~12'h123);

        // R5 vector table
        for (int v = 0; v < NV; v++) begin
            convert(VEC_TGT[v], 12);
            check(code_q == ~VEC_TGT[v] && !busy, "R5 vector", ~code_q, VEC_TGT[v]);
        end

        // R5 exhaustive sweep
        for (int t = 0; t < 4096; t++) begin
            convert(W'(t), 12);
            check(code_q == ~W'(t), "R5 sweep", ~code_q, t);
        end

        // R8 complement pair
        check(msb_n == ~msb && msb == code_q[W-1], "R8", {msb, msb_n}, {code_q[W-1], ~code_q[W-1]});

        // R9 truncated mode
        trunc8 = 1'b1;
        convert(12'hABC, 7);
        check(busy, "R9 busy at 7", busy, 1);
        @(posedge clk); @(negedge clk);
        check(!busy && code_q == ~12'hAB0, "R9 done", code_q, ~12'hAB0);
        check(code_q[3:0] == 4'hF, "R9 low bits", code_q[3:0], 4'hF);
        trunc8 = 1'b0;

        // R6 serial delay
        use_model = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); cmp_force = k[0] ^ k[2];
            @(posedge clk); @(negedge clk);
            check(cmp_dly == (k[0] ^ k[2]), "R6", cmp_dly, k[0] ^ k[2]);
        end
        use_model = 1'b1;

        // R2 restart in mid-conversion
        convert(12'h456, 5);
        start_n = 1'b0;
        @(posedge clk); @(negedge clk);
        start_n = 1'b1;
        check(code_q == 12'h7FF && busy, "R2 restart", code_q, 12'h7FF);
        repeat (12) @(posedge clk);
        @(negedge clk);

        // R7 chaining hold in mid-conversion
        begin
            logic [W-1:0] snap;
            convert(12'h9E1, 3);
            chain_en = 1'b1;
            #1;
            snap = code_q;
            check(msb && !msb_n, "R7 msb forced", {msb, msb_n}, 2'b10);
            start_n = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(code_q[W-2:0] == snap[W-2:0] && busy && msb, "R7 frozen", code_q, snap);
            start_n = 1'b1;
            chain_en = 1'b0;
            repeat (9) @(posedge clk);
            @(negedge clk);
            check(!busy && code_q == ~12'h9E1, "R7 resume", code_q, ~12'h9E1);
        end

        // R10 continuous mode via feedback
        target = 12'h2D4;
        @(negedge clk); feedback = 1'b1;
        @(posedge clk); @(negedge clk);
        check(busy && code_q == 12'h7FF, "R10 first load", code_q, 12'h7FF);
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(!busy && code_q == ~12'h2D4, "R10 result", code_q, ~12'h2D4);
        @(posedge clk); @(negedge clk);
        check(busy && code_q == 12'h7FF, "R10 reload", code_q, 12'h7FF);
        feedback = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule